// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block looks after a single DRAM bank. It takes one memory request at a time from an upstream queue through a valid/ready handshake. Each request is a read or a write to a row address. The block then works out which command the bank needs next: activate a row, precharge, or a column access. It tracks whether the bank is closed or holds an open row, and which row that is. For each command it asks an external timing checker how many cycles must pass before that command is legal. It counts down that delay and raises a ready flag with the command. The bank's state advances when the downstream arbiter reports that the command has been issued.

A parameter fixes the page policy. Under the open-page policy a row hit produces a plain read or write, and the row stays open. Under the closed-page policy a row hit produces a read or write with auto-precharge, and the bank closes. Arbitration across banks, refresh and data movement are handled elsewhere.

Request handling uses three sequencing states:
- `PLAN_IDLE`: no request is held and `req_ready` is high. The transition to `PLAN_DECIDE` happens on an accepted request.
- `PLAN_DECIDE`: lasts one cycle. The block picks the command and queries the checker. It goes to `PLAN_WAIT`, or back to `PLAN_IDLE` on an unsupported request.
- `PLAN_WAIT`: the countdown runs and the command is offered. When the command is issued, ACT or PRE returns the block to `PLAN_DECIDE`. A column command returns it to `PLAN_IDLE`.

The bank itself has two states, `BK_CLOSED` (precharged) and `BK_OPEN` (activated). ACT moves it from `BK_CLOSED` to `BK_OPEN`. PRE, RDA and WRA move it back to `BK_CLOSED`. RD and WR leave it unchanged.

Top module: `bank_cmd_fsm`

## Requirements
- R1: After reset the bank is closed, `req_ready` is 1, and `cmd_ready`, `chk_query` and `err` are 0.
- R2: When a request is held and the bank is closed, the next command is ACT (code 1), and `cmd_row` carries the requested row.
- R3: Under the open-page policy (`CLOSED_PAGE`=0), a request to the open row yields RD (code 3) for a read and WR (code 4) for a write.
- R4: Under the closed-page policy (`CLOSED_PAGE`=1), a row hit yields RDA (code 5) for a read and WRA (code 6) for a write. The bank is then closed, so the next request starts with ACT even if it targets the same row.
- R5: When the bank is open and the requested row differs from the open row, the next command is PRE (code 2), and `cmd_row` carries the open row. It is followed by ACT to the requested row.
- R6: `chk_query` is high for exactly one cycle per command, with `chk_cmd` naming that command. If `chk_delay` in that cycle is D, `cmd_ready` rises exactly D+1 cycles later. It then stays high, with `cmd_code` and `cmd_row` unchanged, until the command is issued.
- R7: Issuing RD or WR leaves the row open, so a following request to the same row goes straight to a column command.
- R8: Issuing RD, WR, RDA or WRA releases the request, and `req_ready` is 1 in the next cycle. Issuing ACT or PRE keeps the request and starts a new decision in the next cycle.
- R9: `req_ready` is 1 only while no request is held. A `req_valid` asserted while `req_ready` is 0 is ignored.
- R10: Operation codes are `req_op`=2'b01 for read and 2'b10 for write. Any other code raises `err` for one cycle in the decision cycle, makes no checker query and issues no command. The request is dropped and the bank state is unchanged.
- R11: `cmd_issue` has no effect while `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | No request held; a request can be taken |
| req_op | input | 2 | 01 read, 10 write, others unsupported |
| req_row | input | ROW_W | Target row of the request |
| chk_query | output | 1 | Checker query valid (decision cycle) |
| chk_cmd | output | 3 | Command whose earliest legal issue is asked |
| chk_delay | input | DLY_W | Cycles the checker demands, sampled with `chk_query` |
| cmd_ready | output | 1 | Command may be issued now |
| cmd_code | output | 3 | 1 ACT, 2 PRE, 3 RD, 4 WR, 5 RDA, 6 WRA |
| cmd_row | output | ROW_W | Row for ACT, open row for the others |
| cmd_issue | input | 1 | Command taken by the arbiter this cycle |
| err | output | 1 | Unsupported request seen |

## Verification
A corrupted bank state or open row shows up at the first checker query after the next request is accepted: the command class changes. For example, RD appears where PRE or ACT was due, or ACT appears on a row hit. This is visible one cycle after acceptance, or one cycle after an ACT or PRE is issued. A wrong countdown shows as `cmd_ready` arriving a cycle early or late relative to the delay returned. A broken hold shows as `cmd_code` changing or `cmd_ready` dropping before `cmd_issue`. The bench uses request sequences of hits, misses and repeated rows, so each of these errors reaches a port within a few cycles.

// File: rtl/bank_fsm_pkg.sv
package bank_fsm_pkg;

    localparam int CMD_W = 3;
    localparam int OP_W  = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_PRE  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4,
        CMD_RDA  = 3'd5,
        CMD_WRA  = 3'd6
    } dram_cmd_e;

    localparam logic [OP_W-1:0] OP_READ  = 2'b01;
    localparam logic [OP_W-1:0] OP_WRITE = 2'b10;

    typedef enum logic [1:0] {
        PLAN_IDLE   = 2'd0,
        PLAN_DECIDE = 2'd1,
        PLAN_WAIT   = 2'd2
    } plan_state_e;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_state_e;

endpackage

// File: rtl/bank_cmd_pick.sv
module bank_cmd_pick
    import bank_fsm_pkg::*;
#(
    parameter int ROW_W       = 14,
    parameter bit CLOSED_PAGE = 1'b0
) (
    input  logic             bank_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [OP_W-1:0]  op,
    input  logic [ROW_W-1:0] row,
    output dram_cmd_e        cmd,
    output logic             bad_op
);

    dram_cmd_e hit_rd;
    dram_cmd_e hit_wr;

    generate
        if (CLOSED_PAGE) begin : g_closed
            assign hit_rd = CMD_RDA;
            assign hit_wr = CMD_WRA;
        end else begin : g_open
            assign hit_rd = CMD_RD;
            assign hit_wr = CMD_WR;
        end
    endgenerate

    always_comb begin
        bad_op = (op != OP_READ) && (op != OP_WRITE);
        cmd    = CMD_NONE;
        if (!bad_op) begin
            if (!bank_open)
                cmd = CMD_ACT;
            else if (row == open_row)
                cmd = (op == OP_READ) ? hit_rd : hit_wr;
            else
                cmd = CMD_PRE;
        end
    end

endmodule

// File: rtl/bank_issue_timer.sv
module bank_issue_timer #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);

    logic [DLY_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/bank_row_track.sv
module bank_row_track
    import bank_fsm_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  dram_cmd_e        cmd,
    input  logic [ROW_W-1:0] act_row,
    output logic             bank_open,
    output logic [ROW_W-1:0] open_row
);

    bank_state_e state_q;
    bank_state_e state_d;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_CLOSED;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire && cmd == CMD_ACT)
                row_q <= act_row;
        end
    end

    always_comb begin
        state_d = state_q;
        if (fire) begin
            unique case (cmd)
                CMD_ACT:                   state_d = BK_OPEN;
                CMD_PRE, CMD_RDA, CMD_WRA: state_d = BK_CLOSED;
                default:                   state_d = state_q;
            endcase
        end
    end

    assign bank_open = (state_q == BK_OPEN);
    assign open_row  = row_q;

endmodule

// File: rtl/bank_cmd_fsm.sv
module bank_cmd_fsm
    import bank_fsm_pkg::*;
#(
    parameter int ROW_W       = 14,
    parameter int DLY_W       = 6,
    parameter bit CLOSED_PAGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    output logic             chk_query,
    output logic [2:0]       chk_cmd,
    input  logic [DLY_W-1:0] chk_delay,
    output logic             cmd_ready,
    output logic [2:0]       cmd_code,
    output logic [ROW_W-1:0] cmd_row,
    input  logic             cmd_issue,
    output logic             err
);

    plan_state_e plan_q;
    plan_state_e plan_d;

    logic [OP_W-1:0]  op_q;
    logic [ROW_W-1:0] row_q;
    dram_cmd_e        cmd_q;

    dram_cmd_e        pick_cmd;
    logic             pick_bad;
    logic             bank_open;
    logic [ROW_W-1:0] open_row;
    logic             timer_load;
    logic             timer_expired;
    logic             fire;
    logic             accept;

    bank_cmd_pick #(
        .ROW_W      (ROW_W),
        .CLOSED_PAGE(CLOSED_PAGE)
    ) u_pick (
        .bank_open(bank_open),
        .open_row (open_row),
        .op       (op_q),
        .row      (row_q),
        .cmd      (pick_cmd),
        .bad_op   (pick_bad)
    );

    bank_issue_timer #(
        .DLY_W(DLY_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(chk_delay),
        .expired (timer_expired)
    );

    bank_row_track #(
        .ROW_W(ROW_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .cmd      (cmd_q),
        .act_row  (row_q),
        .bank_open(bank_open),
        .open_row (open_row)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q <= PLAN_IDLE;
            op_q   <= '0;
            row_q  <= '0;
            cmd_q  <= CMD_NONE;
        end else begin
            plan_q <= plan_d;
            if (accept) begin
                op_q  <= req_op;
                row_q <= req_row;
            end
            if (timer_load)
                cmd_q <= pick_cmd;
        end
    end

    // next-state logic
    always_comb begin
        plan_d = plan_q;
        unique case (plan_q)
            PLAN_IDLE:   if (req_valid) plan_d = PLAN_DECIDE;
            PLAN_DECIDE: plan_d = pick_bad ? PLAN_IDLE : PLAN_WAIT;
            PLAN_WAIT: begin
                if (fire)
                    plan_d = (cmd_q == CMD_ACT || cmd_q == CMD_PRE) ? PLAN_DECIDE : PLAN_IDLE;
            end
            default:     plan_d = PLAN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (plan_q == PLAN_IDLE);
        accept     = req_ready && req_valid;
        chk_query  = (plan_q == PLAN_DECIDE) && !pick_bad;
        err        = (plan_q == PLAN_DECIDE) && pick_bad;
        timer_load = chk_query;
        chk_cmd    = pick_cmd;
        cmd_ready  = (plan_q == PLAN_WAIT) && timer_expired;
        fire       = cmd_ready && cmd_issue;
        cmd_code   = cmd_q;
        cmd_row    = (cmd_q == CMD_ACT) ? row_q : open_row;
    end

endmodule

// File: rtl/bank_cmd_fsm_chk.sv
module bank_cmd_fsm_chk #(
    parameter int ROW_W       = 14,
    parameter int DLY_W       = 6,
    parameter bit CLOSED_PAGE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             chk_query,
    input logic [2:0]       chk_cmd,
    input logic [DLY_W-1:0] chk_delay,
    input logic             cmd_ready,
    input logic [2:0]       cmd_code,
    input logic [ROW_W-1:0] cmd_row,
    input logic             cmd_issue,
    input logic             err
);

    logic fire;
    assign fire = cmd_ready && cmd_issue;

    p_zero_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_query && chk_delay == '0 |=> cmd_ready);

    p_no_early_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_query && chk_delay != '0 |=> !cmd_ready);

    p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && !cmd_issue |=> cmd_ready && $stable(cmd_code) && $stable(cmd_row));

    p_pre_then_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_code == 3'd2 |=> chk_query && chk_cmd == 3'd1);

    generate
        if (CLOSED_PAGE) begin : g_closed_chk
            p_act_then_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
                fire && cmd_code == 3'd1 |=> chk_query && (chk_cmd == 3'd5 || chk_cmd == 3'd6));
        end else begin : g_open_chk
            p_act_then_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
                fire && cmd_code == 3'd1 |=> chk_query && (chk_cmd == 3'd3 || chk_cmd == 3'd4));
        end
    endgenerate

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_code >= 3'd3 |=> req_ready);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !req_ready);

    p_err_no_query_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !chk_query);

    p_err_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> req_ready && !err);

endmodule

bind bank_cmd_fsm bank_cmd_fsm_chk #(
    .ROW_W      (ROW_W),
    .DLY_W      (DLY_W),
    .CLOSED_PAGE(CLOSED_PAGE)
) u_bank_cmd_fsm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .chk_query(chk_query),
    .chk_cmd  (chk_cmd),
    .chk_delay(chk_delay),
    .cmd_ready(cmd_ready),
    .cmd_code (cmd_code),
    .cmd_row  (cmd_row),
    .cmd_issue(cmd_issue),
    .err      (err)
);

// File: tb/bank_cmd_fsm_bench.sv
module bank_cmd_fsm_bench;
    import bank_fsm_pkg::*;

    localparam int ROW_W = 14;
    localparam int DLY_W = 6;
    localparam int NV    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic             req_valid [2];
    logic             req_ready [2];
    logic [1:0]       req_op    [2];
    logic [ROW_W-1:0] req_row   [2];
    logic             chk_query [2];
    logic [2:0]       chk_cmd   [2];
    logic [DLY_W-1:0] chk_delay [2];
    logic             cmd_ready [2];
    logic [2:0]       cmd_code  [2];
    logic [ROW_W-1:0] cmd_row   [2];
    logic             cmd_issue [2];
    logic             err       [2];

    bank_cmd_fsm #(.ROW_W(ROW_W), .DLY_W(DLY_W), .CLOSED_PAGE(1'b0)) u_bank_cmd_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_op(req_op[0]), .req_row(req_row[0]),
        .chk_query(chk_query[0]), .chk_cmd(chk_cmd[0]), .chk_delay(chk_delay[0]),
        .cmd_ready(cmd_ready[0]), .cmd_code(cmd_code[0]), .cmd_row(cmd_row[0]),
        .cmd_issue(cmd_issue[0]), .err(err[0])
    );

    bank_cmd_fsm #(.ROW_W(ROW_W), .DLY_W(DLY_W), .CLOSED_PAGE(1'b1)) u_bank_cmd_fsm_closed (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_op(req_op[1]), .req_row(req_row[1]),
        .chk_query(chk_query[1]), .chk_cmd(chk_cmd[1]), .chk_delay(chk_delay[1]),
        .cmd_ready(cmd_ready[1]), .cmd_code(cmd_code[1]), .cmd_row(cmd_row[1]),
        .cmd_issue(cmd_issue[1]), .err(err[1])
    );

    // vector table for the open-page instance: op, row, delay, expected commands {c2,c1,c0}
    localparam logic [1:0]       V_OP  [NV] = '{OP_READ, OP_WRITE, OP_READ, OP_WRITE, OP_WRITE};
    localparam logic [ROW_W-1:0] V_ROW [NV] = '{14'd5, 14'd5, 14'd9, 14'd9, 14'd3};
    localparam logic [DLY_W-1:0] V_DLY [NV] = '{6'd2, 6'd0, 6'd3, 6'd1, 6'd0};
    localparam logic [8:0]       V_EXP [NV] = '{
        {CMD_NONE, CMD_RD,  CMD_ACT},
        {CMD_NONE, CMD_NONE, CMD_WR},
        {CMD_RD,   CMD_ACT, CMD_PRE},
        {CMD_NONE, CMD_NONE, CMD_WR},
        {CMD_WR,   CMD_ACT, CMD_PRE}
    };

    int nchk  = 0;
    int nfail = 0;
    logic [ROW_W-1:0] open_m [2];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_req(input int k, input logic [1:0] op, input logic [ROW_W-1:0] row);
        chk(req_ready[k] == 1'b1, "R9 req_ready before request", int'(req_ready[k]), 1);
        req_valid[k] = 1'b1;
        req_op[k]    = op;
        req_row[k]   = row;
        @(negedge clk);
        req_valid[k] = 1'b0;
    endtask

    task automatic do_cmd(input int k, input logic [2:0] exp, input logic [DLY_W-1:0] dly,
                          input logic [ROW_W-1:0] rrow, input bit early, input int hold,
                          input bit poke, input string tag);
        logic [ROW_W-1:0] erow;
        int wait_n = 0;
        while (!chk_query[k] && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        chk(chk_query[k] == 1'b1, {tag, " R6 query seen"}, int'(chk_query[k]), 1);
        chk(chk_cmd[k] == exp, {tag, " query command"}, int'(chk_cmd[k]), int'(exp));
        chk_delay[k] = dly;
        for (int n = 1; n <= int'(dly) + 1; n++) begin
            @(negedge clk);
            cmd_issue[k] = 1'b0;
            req_valid[k] = 1'b0;
            if (n < int'(dly) + 1)
                chk(cmd_ready[k] == 1'b0, {tag, " R6 ready early"}, int'(cmd_ready[k]), 0);
            else
                chk(cmd_ready[k] == 1'b1, {tag, " R6 ready on time"}, int'(cmd_ready[k]), 1);
            if (n == 1 && early && dly >= 1)
                cmd_issue[k] = 1'b1;    // R11 premature issue
            if (n == 1 && poke && dly >= 1) begin
                chk(req_ready[k] == 1'b0, {tag, " R9 busy"}, int'(req_ready[k]), 0);
                req_valid[k] = 1'b1;    // R9 ignored request
                req_op[k]    = OP_WRITE;
                req_row[k]   = 14'd1;
            end
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(cmd_ready[k] == 1'b1 && cmd_code[k] == exp, {tag, " R6 hold"}, int'(cmd_code[k]), int'(exp));
        end
        erow = (exp == CMD_ACT) ? rrow : open_m[k];
        chk(cmd_code[k] == exp, {tag, " cmd_code"}, int'(cmd_code[k]), int'(exp));
        chk(cmd_row[k] == erow, {tag, " cmd_row"}, int'(cmd_row[k]), int'(erow));
        if (exp == CMD_ACT) open_m[k] = rrow;
        cmd_issue[k] = 1'b1;
        @(negedge clk);
        cmd_issue[k] = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            req_valid[k] = 1'b0; req_op[k] = '0; req_row[k] = '0;
            chk_delay[k] = '0;  cmd_issue[k] = 1'b0; open_m[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state on both instances
        for (int k = 0; k < 2; k++) begin
            chk(req_ready[k] == 1'b1, "R1 req_ready", int'(req_ready[k]), 1);
            chk(cmd_ready[k] == 1'b0, "R1 cmd_ready", int'(cmd_ready[k]), 0);
            chk(chk_query[k] == 1'b0, "R1 chk_query", int'(chk_query[k]), 0);
            chk(err[k] == 1'b0, "R1 err", int'(err[k]), 0);
        end

        // table walk: R2 R3 R5 R7 R8 on the open-page instance
        for (int v = 0; v < NV; v++) begin
            send_req(0, V_OP[v], V_ROW[v]);
            for (int j = 0; j < 3; j++) begin
                if (V_EXP[v][3*j +: 3] != CMD_NONE)
                    do_cmd(0, V_EXP[v][3*j +: 3], V_DLY[v], V_ROW[v], 1'b0, 0, 1'b0, "R2/R3/R5/R7 vector");
            end
            chk(req_ready[0] == 1'b1, "R8 released after column command", int'(req_ready[0]), 1);
        end

        // R10 unsupported operation codes, bank holds row 3 open
        for (int b = 0; b < 2; b++) begin
            send_req(0, (b == 0) ? 2'b00 : 2'b11, 14'd9);
            chk(err[0] == 1'b1, "R10 err raised", int'(err[0]), 1);
            chk(chk_query[0] == 1'b0, "R10 no query", int'(chk_query[0]), 0);
            @(negedge clk);
            chk(req_ready[0] == 1'b1 && err[0] == 1'b0, "R10 dropped", int'(req_ready[0]), 1);
        end

        // R10 state unchanged and R7 hit: read row 3 goes straight to RD
        // with R11 early issue, R6 hold and R9 ignored request
        send_req(0, OP_READ, 14'd3);
        do_cmd(0, CMD_RD, 6'd3, 14'd3, 1'b1, 2, 1'b1, "R7/R10/R11 hit after error");
        for (int q = 0; q < 3; q++) begin
            chk(chk_query[0] == 1'b0 && req_ready[0] == 1'b1, "R9 ignored request not taken",
                int'(chk_query[0]), 0);
            @(negedge clk);
        end

        // R4 closed-page instance
        send_req(1, OP_READ, 14'd7);
        do_cmd(1, CMD_ACT, 6'd1, 14'd7, 1'b0, 0, 1'b0, "R4 closed first");
        do_cmd(1, CMD_RDA, 6'd1, 14'd7, 1'b0, 0, 1'b0, "R4 closed read");
        chk(req_ready[1] == 1'b1, "R8 released after RDA", int'(req_ready[1]), 1);
        send_req(1, OP_READ, 14'd7);
        do_cmd(1, CMD_ACT, 6'd0, 14'd7, 1'b0, 0, 1'b0, "R4 same row reactivates");
        do_cmd(1, CMD_RDA, 6'd0, 14'd7, 1'b0, 0, 1'b0, "R4 closed read again");
        send_req(1, OP_WRITE, 14'd7);
        do_cmd(1, CMD_ACT, 6'd2, 14'd7, 1'b0, 0, 1'b0, "R4 write activate");
        do_cmd(1, CMD_WRA, 6'd2, 14'd7, 1'b0, 1, 1'b0, "R4 closed write");
        chk(req_ready[1] == 1'b1, "R8 released after WRA", int'(req_ready[1]), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule